// File: doc/BRIEF.md
# CAN Receive Store Arbiter

This block sits between a CAN frame decoder and a bank of 32 message buffers. It decides whether a frame that has just been received is written into its target buffer, and whether that write raises a receive-complete interrupt. Each buffer has a fresh-data flag. A stored frame sets the flag, and software clears it through a clear port. A keep-mode input selects what happens to a frame aimed at a buffer whose flag is still set: the frame either overwrites the buffer or is thrown away.

A free-running 16-bit counter supplies timestamps. A stamp-mode input selects when the counter is sampled. In one setting it is sampled when the frame starts, and that value waits in a staging register. In the other setting it is sampled when the frame is confirmed good. The stamp is written into a buffer only if the frame is actually stored. A read port returns the stamp held by any buffer.

Top module: `can_rx_store`

## Requirements
- R1: After reset, all fresh-data flags are 0, no write enable is high, the interrupt is low, the output data and all stored stamps are 0, and the counter reads 0.
- R2: When a good-frame strobe arrives for a buffer whose flag is clear, the next cycle shows exactly one write enable, at bit position equal to the buffer index. That cycle also shows the frame payload on the data output, and the buffer's flag is set from then on.
- R3: With keep_mode_i = 0, a frame aimed at a buffer whose flag is set is stored all the same, and its payload replaces the earlier one.
- R4: With keep_mode_i = 1, a frame aimed at a buffer whose flag is set is dropped. No write enable goes high, no interrupt is raised, the data output keeps its value, and the buffer's stamp is unchanged.
- R5: The interrupt is high for exactly the cycles in which a write enable is high, one cycle per stored frame.
- R6: With stamp_eof_i = 0, the stamp stored for a frame is the counter value seen in the cycle its start strobe was given.
- R7: With stamp_eof_i = 1, the stamp stored for a frame is the counter value seen in the cycle its good-frame strobe was given.
- R8: An abort strobe, or the end of a frame (stored or dropped), empties the staging register to 0. A later frame that ends without a fresh start strobe, in start-stamp mode, therefore stores stamp 0.
- R9: A clear request clears the flag of the indexed buffer in the next cycle. If a store hits the same buffer in the same cycle, the store wins and the flag stays set.
- R10: The counter advances by one every cycle and wraps from 0xFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Frame start strobe |
| eof_ok_i | input | 1 | Frame confirmed good strobe |
| abort_i | input | 1 | Frame abandoned strobe |
| buf_idx_i | input | 5 | Target buffer of the current frame |
| payload_i | input | 64 | Frame payload |
| keep_mode_i | input | 1 | 1: drop frames aimed at a buffer with fresh data |
| stamp_eof_i | input | 1 | 1: stamp at frame end, 0: stamp at frame start |
| clr_i | input | 1 | Clear request for a fresh-data flag |
| clr_idx_i | input | 5 | Buffer whose flag is cleared |
| ts_rd_idx_i | input | 5 | Buffer whose stored stamp is read |
| buf_we_o | output | 32 | One-hot buffer write enable |
| buf_data_o | output | 64 | Payload accompanying the write enable |
| ts_rd_o | output | 16 | Stored stamp of the buffer chosen by ts_rd_idx_i |
| fresh_o | output | 32 | Fresh-data flags |
| rx_irq_o | output | 1 | Receive-complete pulse |
| ts_cnt_o | output | 16 | Running timestamp counter |

## Verification
The assertions assume that the start, good-frame and abort strobes are never given in the same cycle. They also assume that a good-frame strobe comes with a valid index and payload in that cycle. The stimulus gives at most one strobe per cycle and keeps index and payload steady around each strobe. The flag assertions rely on a clear and a store naming different buffers, except in the one case written to test store priority, which those properties exclude.

// File: rtl/can_rx_store.sv
module can_rx_store #(
  parameter int NBUF = 32,
  parameter int DW   = 64,
  parameter int TSW  = 16,
  localparam int IW  = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof_i,
  input  logic            eof_ok_i,
  input  logic            abort_i,
  input  logic [IW-1:0]   buf_idx_i,
  input  logic [DW-1:0]   payload_i,
  input  logic            keep_mode_i,
  input  logic            stamp_eof_i,
  input  logic            clr_i,
  input  logic [IW-1:0]   clr_idx_i,
  input  logic [IW-1:0]   ts_rd_idx_i,
  output logic [NBUF-1:0] buf_we_o,
  output logic [DW-1:0]   buf_data_o,
  output logic [TSW-1:0]  ts_rd_o,
  output logic [NBUF-1:0] fresh_o,
  output logic            rx_irq_o,
  output logic [TSW-1:0]  ts_cnt_o
);

  logic [TSW-1:0] cnt, stage;
  logic [TSW-1:0] ts_mem [NBUF];

  wire blocked = keep_mode_i & fresh_o[buf_idx_i];
  wire store   = eof_ok_i & ~blocked;

  assign ts_cnt_o = cnt;
  assign ts_rd_o  = ts_mem[ts_rd_idx_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      stage      <= '0;
      fresh_o    <= '0;
      buf_we_o   <= '0;
      buf_data_o <= '0;
      rx_irq_o   <= 1'b0;
      for (int i = 0; i < NBUF; i++) ts_mem[i] <= '0;
    end else begin
      cnt      <= cnt + 1'b1;
      rx_irq_o <= store;
      buf_we_o <= store ? (NBUF'(1) << buf_idx_i) : '0;
      if (sof_i)                   stage <= cnt;
      else if (eof_ok_i | abort_i) stage <= '0;
      if (clr_i) fresh_o[clr_idx_i] <= 1'b0;
      if (store) begin
        fresh_o[buf_idx_i] <= 1'b1;
        buf_data_o         <= payload_i;
        ts_mem[buf_idx_i]  <= stamp_eof_i ? cnt : stage;
      end
    end
  end

  // R5
  irq_we_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o == ($countones(buf_we_o) == 1) && $onehot0(buf_we_o));

  // R4
  drop_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_ok_i && keep_mode_i && fresh_o[buf_idx_i]) |=> (!rx_irq_o && buf_we_o == '0));

  // R2
  store_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_ok_i && !(keep_mode_i && fresh_o[buf_idx_i])) |=> fresh_o[$past(buf_idx_i)]);

  // R9
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(eof_ok_i && buf_idx_i == clr_idx_i)) |=> !fresh_o[$past(clr_idx_i)]);

  // R10
  counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ts_cnt_o == TSW'($past(ts_cnt_o) + 1'b1));

  // R4
  drop_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_ok_i && keep_mode_i && fresh_o[buf_idx_i]) |=> $stable(buf_data_o));

endmodule

// File: tb/test_can_rx_store.sv
module test_can_rx_store;
  logic clk = 0, rst_n = 0;
  logic sof = 0, eof = 0, abrt = 0, keep = 0, seof = 0, clr = 0;
  logic [4:0] idx = 0, clr_idx = 0, rd_idx = 0;
  logic [63:0] pay = 0;
  logic [31:0] we; logic [63:0] data; logic [15:0] ts_rd, tcnt; logic [31:0] fresh; logic irq;

  always #4 clk = ~clk;

  can_rx_store i_can_rx_store (.clk, .rst_n, .sof_i(sof), .eof_ok_i(eof), .abort_i(abrt),
    .buf_idx_i(idx), .payload_i(pay), .keep_mode_i(keep), .stamp_eof_i(seof), .clr_i(clr),
    .clr_idx_i(clr_idx), .ts_rd_idx_i(rd_idx), .buf_we_o(we), .buf_data_o(data),
    .ts_rd_o(ts_rd), .fresh_o(fresh), .rx_irq_o(irq), .ts_cnt_o(tcnt));

  int tests = 0, fails = 0, cyc_n = 0;
  int m_cnt = 0, m_stage = 0;
  bit [31:0] m_fresh = 0, m_we = 0; bit m_irq = 0; bit [63:0] m_data = 0;
  int m_ts[32];
  bit saw_irq;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic model();
    bit st;
    if (!rst_n) begin
      m_cnt = 0; m_stage = 0; m_fresh = 0; m_we = 0; m_irq = 0; m_data = 0;
      foreach (m_ts[i]) m_ts[i] = 0;
      return;
    end
    st = eof && !(keep && m_fresh[idx]);
    m_irq = st; m_we = st ? (32'd1 << idx) : 0;
    if (st) begin m_data = pay; m_ts[idx] = seof ? m_cnt : m_stage; end
    if (sof) m_stage = m_cnt; else if (eof || abrt) m_stage = 0;
    if (clr) m_fresh[clr_idx] = 0;
    if (st) m_fresh[idx] = 1;
    m_cnt = (m_cnt + 1) % 65536;
  endtask

  task automatic cyc();
    @(posedge clk); model();
    @(negedge clk);
    cyc_n++;
    if (irq) saw_irq = 1;
    chk(we == m_we, "R2 write enable", we, m_we);
    chk(irq == m_irq, "R5 interrupt", irq, m_irq);
    chk(data == m_data, "R2 data", data, m_data);
    chk(fresh == m_fresh, "R9 flags", fresh, m_fresh);
    chk(ts_rd == 16'(m_ts[rd_idx]), "R6 stamp read", ts_rd, m_ts[rd_idx]);
    chk(tcnt == 16'(m_cnt), "R10 counter", tcnt, m_cnt);
    sof = 0; eof = 0; abrt = 0; clr = 0;
    rd_idx = 5'(cyc_n);
  endtask

  task automatic frame(input logic [4:0] b, input logic [63:0] p, output int t_sof, output int t_eof);
    idx = b; pay = p; sof = 1; t_sof = tcnt; cyc();
    repeat (3) cyc();
    idx = b; pay = p; eof = 1; t_eof = tcnt; saw_irq = 0; cyc();
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ts0, te0;
    repeat (3) cyc();
    // R1
    chk(fresh == 0 && we == 0 && !irq && tcnt == 0, "R1 reset state", {fresh, we}, 0);
    rst_n = 1;
    repeat (4) cyc();
    // R2 R6
    rd_idx = 5; frame(5, 64'hA, ts0, te0);
    chk(saw_irq && data == 64'hA, "R2 stored", data, 64'hA);
    rd_idx = 5; #0; chk(ts_rd == 16'(ts0), "R6 start stamp", ts_rd, ts0);
    chk(fresh[5], "R2 flag set", fresh[5], 1);
    // R3
    frame(5, 64'hB, ts0, te0);
    chk(saw_irq && data == 64'hB, "R3 overwrite", data, 64'hB);
    // R4
    keep = 1; frame(5, 64'hC, ts0, te0);
    chk(!saw_irq && data == 64'hB, "R4 dropped", data, 64'hB);
    // R7
    seof = 1; frame(9, 64'hD, ts0, te0);
    rd_idx = 9; #0; chk(ts_rd == 16'(te0), "R7 end stamp", ts_rd, te0);
    // R8
    seof = 0; idx = 12; sof = 1; cyc(); cyc(); abrt = 1; cyc(); cyc();
    idx = 12; pay = 64'hE; eof = 1; cyc();
    rd_idx = 12; #0; chk(ts_rd == 0, "R8 stage emptied", ts_rd, 0);
    // R9
    clr = 1; clr_idx = 5; cyc();
    chk(!fresh[5], "R9 cleared", fresh[5], 0);
    frame(5, 64'hF, ts0, te0);
    chk(saw_irq && data == 64'hF, "R9 store after clear", data, 64'hF);
    keep = 0; idx = 9; pay = 64'h10; eof = 1; clr = 1; clr_idx = 9; cyc();
    chk(fresh[9], "R9 store beats clear", fresh[9], 1);
    // R10
    while (tcnt != 16'hFFFF) cyc();
    cyc();
    chk(tcnt == 0, "R10 wrap", tcnt, 0);
    repeat (4) cyc();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule